// File: doc/BRIEF.md
# Lock-Aware Translation Buffer

A fully associative translation buffer with 64 slots. Each slot pairs a tag word with a translation word. Bit 63 of the translation word marks the slot as valid, and bit 6 marks it as locked against replacement.

Software reaches the buffer through a command port that carries four commands:

- A register command reads or writes a small bank of control registers. One of them is the tag-staging register, which supplies the tag for every slot write.
- A replacement fill places a new translation in a slot that the buffer chooses.
- An indexed slot command writes or reads one slot named by address.
- A probe searches for a valid slot whose tag equals a given value.

The register bank also holds a fault-status register and a fault-address register. A hardware fault-capture input loads both. A software write to the fault-status register either stores a value or clears both registers, depending on bit 0 of the written value. Translation of live memory traffic and table walking are not part of this block.

Every read-type request returns its answer on a registered response port one cycle later.

Top module: `xlat_buffer`

## Requirements
- R1: After synchronous active-low reset, every slot is invalid, reading any slot's translation word or any register returns zero, and `rsp_valid` is low.
- R2: A request with `req_write` low produces `rsp_valid` high with its data in the cycle after the request edge. A write request produces no response.
- R3: A fill (`req_cmd` = 1) stores the tag-staging register (register 6) as the tag and `req_wdata` as the translation word. It goes into the lowest-index slot whose bit 63 is clear.
- R4: When no slot is invalid, a fill goes into the lowest-index slot whose lock bit (bit 6) is clear. An invalid slot is always preferred, even if its lock bit is set.
- R5: When every slot is valid and locked, a fill changes no slot.
- R6: An indexed slot write (`req_cmd` = 2) overwrites the slot numbered by `req_dw_addr` unconditionally, taking its tag from register 6. An indexed slot read returns that slot's translation word.
- R7: A probe (`req_cmd` = 3, probe value on `req_wdata`) returns the tag of the lowest-index valid slot whose tag equals the probe. It returns zero when no valid slot matches, so invalid slots never match.
- R8: A register command (`req_cmd` = 0) uses the low four bits of `req_dw_addr` as the register index. Writes to registers 0 and 4 have no effect. Other registers other than 3 store the written value and read it back.
- R9: Writing register 3 (fault status) with bit 0 clear sets both register 3 and register 4 (fault address) to zero. Writing it with bit 0 set stores the value in register 3.
- R10: A cycle with `flt_valid` high loads `flt_status` into register 3 and `flt_addr` into register 4. If software writes register 3 in the same cycle, the capture is discarded and the software write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 2 | 0 register, 1 fill, 2 indexed slot, 3 probe |
| req_dw_addr | input | 6 | Doubleword address: slot number, or register index in its low 4 bits |
| req_wdata | input | 64 | Write data or probe value |
| flt_valid | input | 1 | Hardware fault capture strobe |
| flt_status | input | 64 | Captured fault status |
| flt_addr | input | 64 | Captured fault address |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 64 | Read response data |

## Verification
The assertions check the following properties on every cycle:

- Response timing for reads and writes.
- A fill into a buffer that still has an invalid slot grows the valid count by exactly one.
- A fill into a full, fully locked buffer leaves the valid and lock vectors untouched.
- Probe responses are zero on a miss and equal the probe on a hit.
- Register 0 always reads zero.

Only the bench's scenarios can show the following properties, which it checks against a reference model:

- Which slot a fill lands in, and that invalid slots are preferred over unlocked ones.
- That register 4 ignores writes while still taking captured addresses.
- That a fault-status clear zeroes the address register.
- That software beats capture when both happen in the same cycle.

// File: rtl/xlat_pkg.sv
// Shared definitions for the translation buffer.
// Assumes: command codes are fixed by software convention.
package xlat_pkg;
    typedef enum logic [1:0] {
        CMD_REG   = 2'd0,
        CMD_FILL  = 2'd1,
        CMD_SLOT  = 2'd2,
        CMD_PROBE = 2'd3
    } xlat_cmd_e;
endpackage

// File: rtl/xlat_lowest_set.sv
// Priority encoder: reports whether any bit is set and the index of the
// lowest set bit. Purely combinational, single level of selection.
// Assumes: N is a power of two or at least 2.
module xlat_lowest_set #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any = |vec;
endmodule

// File: rtl/xlat_entry_array.sv
// Slot storage: tag and translation word per slot, with per-slot valid,
// lock and probe-match decoding. One write port, one indexed read port,
// one associative probe port.
// Assumes: only translation words are reset; tags are don't-care while invalid.
module xlat_entry_array #(
    parameter int ENTRIES   = 64,
    parameter int WORD_W    = 64,
    parameter int VALID_BIT = 63,
    parameter int LOCK_BIT  = 6,
    parameter int IW        = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IW-1:0]      widx,
    input  logic [WORD_W-1:0]  wtag,
    input  logic [WORD_W-1:0]  wword,
    input  logic [IW-1:0]      ridx,
    input  logic [WORD_W-1:0]  probe,
    output logic [WORD_W-1:0]  rword,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] lock_vec,
    output logic               hit,
    output logic [WORD_W-1:0]  hit_tag
);
    logic [WORD_W-1:0]  tag_q  [ENTRIES];
    logic [WORD_W-1:0]  word_q [ENTRIES];
    logic [ENTRIES-1:0] match_vec;
    logic [IW-1:0]      hit_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Translation word: cleared on reset, replaced on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                          word_q[g] <= '0;
            else if (we && widx == IW'(g))       word_q[g] <= wword;
        end

        // Tag word: replaced on a write to this slot.
        always_ff @(posedge clk) begin
            if (we && widx == IW'(g)) tag_q[g] <= wtag;
        end

        assign valid_vec[g] = word_q[g][VALID_BIT];
        assign lock_vec[g]  = word_q[g][LOCK_BIT];
        assign match_vec[g] = word_q[g][VALID_BIT] && (tag_q[g] == probe);
    end

    xlat_lowest_set #(.N(ENTRIES), .IW(IW)) u_probe_pick (
        .vec (match_vec),
        .any (hit),
        .idx (hit_idx)
    );

    assign hit_tag = tag_q[hit_idx];
    assign rword   = word_q[ridx];
endmodule

// File: rtl/xlat_mmu_regs.sv
// Control register bank: plain registers plus a read-only slot, a fault
// status register with clear-on-bit0-low semantics and a fault address
// register loaded only by hardware capture or cleared by that status write.
// Assumes: software write to the status register beats a same-cycle capture.
module xlat_mmu_regs #(
    parameter int REGS    = 16,
    parameter int WORD_W  = 64,
    parameter int RO_IDX  = 0,
    parameter int FSR_IDX = 3,
    parameter int FAR_IDX = 4,
    parameter int TAG_IDX = 6,
    parameter int RIW     = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIW-1:0]    widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              cap_valid,
    input  logic [WORD_W-1:0] cap_status,
    input  logic [WORD_W-1:0] cap_addr,
    input  logic [RIW-1:0]    ridx,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] tag_stage
);
    logic [WORD_W-1:0] regs_q [REGS];
    logic              fsr_wr;

    assign fsr_wr = we && (widx == RIW'(FSR_IDX));

    for (genvar g = 0; g < REGS; g++) begin : g_reg
        if (g == RO_IDX) begin : g_ro
            // Read-only slot: holds zero forever.
            always_ff @(posedge clk) regs_q[g] <= '0;
        end else if (g == FSR_IDX) begin : g_fsr
            // Fault status: software store or clear, else hardware capture.
            always_ff @(posedge clk) begin
                if (!rst_n)         regs_q[g] <= '0;
                else if (fsr_wr)    regs_q[g] <= wdata[0] ? wdata : '0;
                else if (cap_valid) regs_q[g] <= cap_status;
            end
        end else if (g == FAR_IDX) begin : g_far
            // Fault address: cleared with status, else hardware capture.
            always_ff @(posedge clk) begin
                if (!rst_n)                 regs_q[g] <= '0;
                else if (fsr_wr)            regs_q[g] <= wdata[0] ? regs_q[g] : '0;
                else if (cap_valid)         regs_q[g] <= cap_addr;
            end
        end else begin : g_rw
            // Ordinary read/write register.
            always_ff @(posedge clk) begin
                if (!rst_n)                      regs_q[g] <= '0;
                else if (we && widx == RIW'(g))  regs_q[g] <= wdata;
            end
        end
    end

    assign rdata     = regs_q[ridx];
    assign tag_stage = regs_q[TAG_IDX];
endmodule

// File: rtl/xlat_buffer.sv
// Top of the translation buffer. Decodes the command port, picks the fill
// victim (lowest invalid slot, else lowest unlocked slot, else none) and
// registers every read response for one cycle.
// Assumes: one request per cycle; REGS does not exceed ENTRIES.
module xlat_buffer #(
    parameter int ENTRIES   = 64,
    parameter int WORD_W    = 64,
    parameter int VALID_BIT = 63,
    parameter int LOCK_BIT  = 6,
    parameter int REGS      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [1:0]                 req_cmd,
    input  logic [$clog2(ENTRIES)-1:0] req_dw_addr,
    input  logic [WORD_W-1:0]          req_wdata,
    input  logic                       flt_valid,
    input  logic [WORD_W-1:0]          flt_status,
    input  logic [WORD_W-1:0]          flt_addr,
    output logic                       rsp_valid,
    output logic [WORD_W-1:0]          rsp_data
);
    import xlat_pkg::*;

    localparam int IW  = $clog2(ENTRIES);
    localparam int RIW = $clog2(REGS);

    xlat_cmd_e          cmd;
    logic               is_rd, is_wr;
    logic [ENTRIES-1:0] valid_vec, lock_vec;
    logic               inv_any, unl_any, fill_ok;
    logic [IW-1:0]      inv_idx, unl_idx, fill_idx;
    logic               arr_we;
    logic [IW-1:0]      arr_widx;
    logic [WORD_W-1:0]  slot_word, probe_tag, reg_rdata, tag_stage;
    logic               probe_hit;
    logic               reg_we;
    logic [RIW-1:0]     reg_idx;
    logic [WORD_W-1:0]  rd_mux;

    assign cmd     = xlat_cmd_e'(req_cmd);
    assign is_rd   = req_valid && !req_write;
    assign is_wr   = req_valid && req_write;
    assign reg_idx = req_dw_addr[RIW-1:0];

    // Victim selection: two priority encoders, invalid before unlocked.
    xlat_lowest_set #(.N(ENTRIES), .IW(IW)) u_pick_inv (
        .vec (~valid_vec),
        .any (inv_any),
        .idx (inv_idx)
    );

    xlat_lowest_set #(.N(ENTRIES), .IW(IW)) u_pick_unl (
        .vec (~lock_vec),
        .any (unl_any),
        .idx (unl_idx)
    );

    assign fill_ok  = inv_any || unl_any;
    assign fill_idx = inv_any ? inv_idx : unl_idx;

    // Slot write decode: fills only when a victim exists; indexed always.
    always_comb begin
        arr_we   = 1'b0;
        arr_widx = req_dw_addr;
        if (is_wr && cmd == CMD_FILL && fill_ok) begin
            arr_we   = 1'b1;
            arr_widx = fill_idx;
        end else if (is_wr && cmd == CMD_SLOT) begin
            arr_we   = 1'b1;
        end
    end

    assign reg_we = is_wr && (cmd == CMD_REG);

    xlat_entry_array #(
        .ENTRIES   (ENTRIES),
        .WORD_W    (WORD_W),
        .VALID_BIT (VALID_BIT),
        .LOCK_BIT  (LOCK_BIT),
        .IW        (IW)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (arr_we),
        .widx      (arr_widx),
        .wtag      (tag_stage),
        .wword     (req_wdata),
        .ridx      (req_dw_addr),
        .probe     (req_wdata),
        .rword     (slot_word),
        .valid_vec (valid_vec),
        .lock_vec  (lock_vec),
        .hit       (probe_hit),
        .hit_tag   (probe_tag)
    );

    xlat_mmu_regs #(
        .REGS   (REGS),
        .WORD_W (WORD_W),
        .RIW    (RIW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .widx       (reg_idx),
        .wdata      (req_wdata),
        .cap_valid  (flt_valid),
        .cap_status (flt_status),
        .cap_addr   (flt_addr),
        .ridx       (reg_idx),
        .rdata      (reg_rdata),
        .tag_stage  (tag_stage)
    );

    // Read data selection by command.
    always_comb begin
        unique case (cmd)
            CMD_REG:   rd_mux = reg_rdata;
            CMD_SLOT:  rd_mux = slot_word;
            CMD_PROBE: rd_mux = probe_hit ? probe_tag : '0;
            default:   rd_mux = '0;
        endcase
    end

    // Response register: one cycle after each read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= is_rd;
            if (is_rd) rsp_data <= rd_mux;
        end
    end
endmodule

// File: rtl/xlat_buffer_chk.sv
// Cycle-level checks on the translation buffer, bound to the top module.
// Assumes: observes ports plus the slot valid/lock vectors and probe hit.
module xlat_buffer_chk #(
    parameter int ENTRIES   = 64,
    parameter int WORD_W    = 64,
    parameter int VALID_BIT = 63
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [1:0]                 req_cmd,
    input logic [$clog2(ENTRIES)-1:0] req_dw_addr,
    input logic [WORD_W-1:0]          req_wdata,
    input logic                       rsp_valid,
    input logic [WORD_W-1:0]          rsp_data,
    input logic [ENTRIES-1:0]         valid_vec,
    input logic [ENTRIES-1:0]         lock_vec,
    input logic                       probe_hit
);
    import xlat_pkg::*;

    logic rd_req, fill_wr, probe_rd;
    assign rd_req   = req_valid && !req_write;
    assign fill_wr  = req_valid && req_write && req_cmd == 2'(CMD_FILL);
    assign probe_rd = rd_req && req_cmd == 2'(CMD_PROBE);

    a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

    a_r2_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

    a_r3_fill_adds_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_wr && !(&valid_vec) && req_wdata[VALID_BIT])
        |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    a_r5_locked_full_fill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_wr && (&valid_vec) && (&lock_vec))
        |=> ($stable(valid_vec) && $stable(lock_vec)));

    a_r7_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_rd && !probe_hit) |=> (rsp_data == '0));

    a_r7_hit_reads_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_rd && probe_hit) |=> (rsp_data == $past(req_wdata)));

    a_r8_reg0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_cmd == 2'(CMD_REG) && req_dw_addr[3:0] == 4'd0)
        |=> (rsp_data == '0));
endmodule

bind xlat_buffer xlat_buffer_chk #(
    .ENTRIES   (ENTRIES),
    .WORD_W    (WORD_W),
    .VALID_BIT (VALID_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_cmd     (req_cmd),
    .req_dw_addr (req_dw_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .valid_vec   (valid_vec),
    .lock_vec    (lock_vec),
    .probe_hit   (probe_hit)
);

// File: tb/test_xlat_buffer.sv
// Bench: directed corner cases followed by seeded random traffic, every
// read compared against a behavioural model kept in bench arrays.
module test_xlat_buffer;
    localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LB = 64'h0000_0000_0000_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_cmd = '0;
    logic [5:0]  req_dw_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        flt_valid = 1'b0;
    logic [63:0] flt_status = '0, flt_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_tag  [64];
    logic [63:0] m_word [64];
    logic [63:0] m_reg  [16];

    always #10 clk = ~clk;

    xlat_buffer i_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cmd(req_cmd), .req_dw_addr(req_dw_addr), .req_wdata(req_wdata),
        .flt_valid(flt_valid), .flt_status(flt_status), .flt_addr(flt_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int m_victim();
        for (int i = 0; i < 64; i++) if (!m_word[i][63]) return i;
        for (int i = 0; i < 64; i++) if (!m_word[i][6]) return i;
        return -1;
    endfunction

    function automatic logic [63:0] m_probe(input logic [63:0] p);
        for (int i = 0; i < 64; i++) if (m_word[i][63] && m_tag[i] == p) return m_tag[i];
        return '0;
    endfunction

    task automatic m_reg_write(input int idx, input logic [63:0] d);
        if (idx == 0 || idx == 4) return;
        if (idx == 3) begin
            if (!d[0]) begin m_reg[3] = '0; m_reg[4] = '0; end
            else m_reg[3] = d;
        end else m_reg[idx] = d;
    endtask

    task automatic drive(input logic [1:0] c, input logic w, input logic [5:0] a,
                         input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_cmd = c; req_dw_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Write operations with model update.
    task automatic wr_reg(input int idx, input logic [63:0] d);
        drive(2'd0, 1'b1, 6'(idx), d);
        m_reg_write(idx, d);
        check(rsp_valid == 1'b0, "R2 write gives no response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic wr_fill(input logic [63:0] d);
        int v;
        v = m_victim();
        drive(2'd1, 1'b1, 6'd0, d);
        if (v >= 0) begin m_tag[v] = m_reg[6]; m_word[v] = d; end
    endtask

    task automatic wr_slot(input int s, input logic [63:0] d);
        drive(2'd2, 1'b1, 6'(s), d);
        m_tag[s] = m_reg[6]; m_word[s] = d;
    endtask

    // Read operations checked against the model state before the edge.
    task automatic rd_reg(input int idx, input string req);
        logic [63:0] e;
        e = m_reg[idx];
        drive(2'd0, 1'b0, 6'(idx), 64'd0);
        check(rsp_valid && rsp_data == e, req, rsp_data, e);
    endtask

    task automatic rd_slot(input int s, input string req);
        logic [63:0] e;
        e = m_word[s];
        drive(2'd2, 1'b0, 6'(s), 64'd0);
        check(rsp_valid && rsp_data == e, req, rsp_data, e);
    endtask

    task automatic rd_probe(input logic [63:0] p, input string req);
        logic [63:0] e;
        e = m_probe(p);
        drive(2'd3, 1'b0, 6'd0, p);
        check(rsp_valid && rsp_data == e, req, rsp_data, e);
    endtask

    task automatic capture(input logic [63:0] s, input logic [63:0] a);
        @(negedge clk);
        req_valid = 1'b0;
        flt_valid = 1'b1; flt_status = s; flt_addr = a;
        @(posedge clk);
        #1;
        m_reg[3] = s; m_reg[4] = a;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_word[i] = '0; end
        for (int i = 0; i < 16; i++) m_reg[i] = '0;

        repeat (3) @(posedge clk);
        #1;
        check(rsp_valid == 1'b0, "R1 no response in reset", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_slot(0, "R1 slot 0 cleared");
        rd_slot(63, "R1 slot 63 cleared");
        rd_reg(6, "R1 tag register cleared");
        rd_reg(3, "R1 fault status cleared");
        idle();
        @(posedge clk); #1;
        check(rsp_valid == 1'b0, "R2 idle gives no response", 64'(rsp_valid), 64'd0);

        // R3: fills go to lowest invalid slots with the staged tag
        wr_reg(6, 64'h1111_0000_0000_2000);
        wr_fill(VB | 64'h123);
        wr_reg(6, 64'h2222_0000_0000_4000);
        wr_fill(VB | LB | 64'h456);
        rd_slot(0, "R3 first fill in slot 0");
        rd_slot(1, "R3 second fill in slot 1");
        rd_probe(64'h1111_0000_0000_2000, "R3 staged tag stored");
        rd_probe(64'h2222_0000_0000_4000, "R3 staged tag stored");

        // R7: miss and invalid slot do not match
        rd_probe(64'h9999_9999_9999_9999, "R7 miss reads zero");
        wr_reg(6, 64'h3333_0000_0000_6000);
        wr_slot(5, 64'h789);
        rd_probe(64'h3333_0000_0000_6000, "R7 invalid slot never matches");

        // R6 and R5: fill every slot valid and locked, then fill is dropped
        for (int i = 0; i < 64; i++) begin
            wr_reg(6, 64'(i + 100));
            wr_slot(i, VB | LB | 64'(i));
        end
        rd_slot(37, "R6 indexed write stored");
        rd_probe(64'd137, "R6 indexed tag stored");
        wr_reg(6, 64'hDEAD);
        wr_fill(VB | 64'hAAAA);
        for (int i = 0; i < 64; i++) rd_slot(i, "R5 locked full buffer unchanged");
        rd_probe(64'hDEAD, "R5 dropped fill left no tag");

        // R4: lowest unlocked slot chosen; invalid slot preferred over it
        wr_reg(6, 64'd40);
        wr_slot(40, VB | 64'h1);
        wr_reg(6, 64'd20);
        wr_slot(20, VB | 64'h2);
        wr_reg(6, 64'hBEEF);
        wr_fill(VB | LB | 64'h3);
        rd_slot(20, "R4 lowest unlocked slot replaced");
        rd_slot(40, "R4 higher unlocked slot kept");
        wr_slot(7, LB | 64'h5);
        wr_reg(6, 64'hCAFE);
        wr_fill(VB | 64'h6);
        rd_slot(7, "R4 invalid locked slot preferred");
        rd_slot(40, "R4 unlocked slot untouched when invalid exists");

        // R8: register index and read-only registers
        wr_reg(0, 64'hFFFF);
        rd_reg(0, "R8 register 0 ignores writes");
        wr_reg(4, 64'hABCD);
        rd_reg(4, "R8 register 4 ignores writes");
        wr_reg(9, 64'h0123_4567_89AB_CDEF);
        rd_reg(9, "R8 register stores value");

        // R9, R10: fault registers
        capture(64'h55, 64'h7777_0000);
        rd_reg(3, "R10 capture loads status");
        rd_reg(4, "R10 capture loads address");
        wr_reg(3, 64'hF1);
        rd_reg(3, "R9 status stored with bit0 set");
        rd_reg(4, "R9 address kept with bit0 set");
        wr_reg(3, 64'hF0);
        rd_reg(3, "R9 status cleared");
        rd_reg(4, "R9 address cleared");
        capture(64'h77, 64'h8888);
        @(negedge clk);
        flt_valid = 1'b1; flt_status = 64'h99; flt_addr = 64'h4444;
        req_valid = 1'b1; req_write = 1'b1; req_cmd = 2'd0; req_dw_addr = 6'd3;
        req_wdata = 64'h0;
        @(posedge clk); #1;
        m_reg_write(3, 64'h0);
        @(negedge clk);
        flt_valid = 1'b0;
        rd_reg(3, "R10 software write beats capture");
        rd_reg(4, "R10 capture address discarded");

        // Seeded random traffic checked against the model
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [63:0] d;
            op = int'($urandom % 9);
            d  = {$urandom, $urandom};
            case (op)
                0, 1: begin
                    d[63] = $urandom_range(0, 3) != 0;
                    d[6]  = $urandom_range(0, 1) == 1;
                    wr_fill(d);
                end
                2: begin
                    d[63] = $urandom_range(0, 1) == 1;
                    wr_slot(int'($urandom % 64), d);
                end
                3: rd_slot(int'($urandom % 64), "R6 random slot read");
                4: begin
                    if ($urandom_range(0, 3) != 0) rd_probe(m_tag[$urandom % 64], "R7 random probe");
                    else rd_probe(d, "R7 random probe");
                end
                5: wr_reg(int'($urandom % 16), d);
                6: rd_reg(int'($urandom % 16), "R8 random register read");
                7: capture(d, {$urandom, $urandom});
                default: wr_reg(6, {56'd0, 8'($urandom)});
            endcase
        end
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule